// File: doc/BRIEF.md
# Host and Sequencer Shared Interrupt Status Register

This block is a byte-wide control and status register that sits between a host bus interface and an on-chip script sequencer inside a bus controller. Each bit has its own update rule. A sticky soft-reset bit holds the other operating registers of the controller in reset. A signal flag lets the host wake the sequencer or redirect it. A semaphore can be raised from either side. A connected flag follows bus-state events. An interrupt-on-the-fly flag is cleared by writing a one to it.

The host reads and writes the byte through a plain write strobe and a combinational read bus. The sequencer can write the semaphore. The bus-protocol engine delivers single-cycle event strobes. A test/status port reads the signal flag and clears it as a side effect. Two external interrupt-pending lines are copied into the low bits and merged into the interrupt output. A compatibility configuration bit is kept outside the soft-reset domain.

Read layout of the byte: bit 7 always 0, bit 6 soft reset, bit 5 signal flag, bit 4 semaphore, bit 3 connected, bit 2 interrupt-on-the-fly, bit 1 bus-interrupt pending, bit 0 DMA-interrupt pending.

Top module: `isr_ctl`

## Requirements
- R1: After a hardware reset (rst_n low) `host_rdata` reads 0x00 apart from bits 1..0, and `compat_mode` is 0.
- R2: The soft-reset bit (bit 6) follows the host write data. Once set, it stays set until a host write with bit 6 at 0 or a hardware reset.
- R3: While bit 6 is set, `ops_rst` is high and bits 5..2 read 0. Host writes and events that would set those bits are held off.
- R4: `compat_mode` changes only on `cfg_wr` or on a hardware reset. The soft reset leaves it as it is.
- R5: The signal flag (bit 5) takes the value of host write bit 5. A `tst_rd` strobe clears it, and `tst_sigp` shows it. A host write of 1 in the same cycle as `tst_rd` leaves it set.
- R6: `sel_abort` is high exactly when the signal flag is set and `seq_wait_sel` is high.
- R7: The semaphore (bit 4) is written by host bit 4 or by `seq_sem_val` on `seq_sem_wr`. If either writer supplies a 1 in a cycle, the result is 1.
- R8: Any of `ev_sel_done`, `ev_resp_sel` or `ev_arb_won` sets the connected bit (bit 3), and `ev_disc` clears it. A set strobe wins over a clear in the same cycle. Host writes do not change this bit.
- R9: `ev_intfly` sets bit 2. Reads and host writes of 0 leave it unchanged. A host write with bit 2 at 1 clears it, but `ev_intfly` in the same cycle wins.
- R10: Bits 1 and 0 mirror `sip_in` and `dip_in`, and host writes do not affect them. Bit 7 reads 0. `irq` is the OR of `sip_in`, `dip_in` and bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read value |
| seq_sem_wr | input | 1 | Sequencer semaphore write strobe |
| seq_sem_val | input | 1 | Sequencer semaphore write value |
| tst_rd | input | 1 | Test-port read of the signal flag, clears it |
| tst_sigp | output | 1 | Signal flag as seen by the test port |
| seq_wait_sel | input | 1 | Sequencer is in a wait-for-selection instruction |
| sel_abort | output | 1 | Take the alternate branch of the wait instruction |
| ev_sel_done | input | 1 | Selection completed |
| ev_resp_sel | input | 1 | Responded to a bus-initiated (re)selection |
| ev_arb_won | input | 1 | Arbitration won in low-level mode |
| ev_disc | input | 1 | Disconnected from the bus |
| ev_intfly | input | 1 | Interrupt-on-the-fly instruction strobe |
| sip_in | input | 1 | Bus-interrupt pending |
| dip_in | input | 1 | DMA-interrupt pending |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_compat | input | 1 | Compatibility bit write value |
| compat_mode | output | 1 | Compatibility configuration bit |
| ops_rst | output | 1 | Reset to other operating registers and bus drivers |
| irq | output | 1 | Interrupt request |

## Verification
The block has no parameters, so the bench builds it in its one configuration and every bit of the byte is reachable. The stimulus targets the same-cycle collisions: host set against test-port clear, host write against sequencer write, connect against disconnect, and instruction strobe against write-one-to-clear. It then sets the soft reset with all flags raised, to show that they are held off while the compatibility bit survives.

// File: rtl/isr_ctl.sv
module isr_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       seq_sem_wr,
  input  logic       seq_sem_val,
  input  logic       tst_rd,
  output logic       tst_sigp,
  input  logic       seq_wait_sel,
  output logic       sel_abort,
  input  logic       ev_sel_done,
  input  logic       ev_resp_sel,
  input  logic       ev_arb_won,
  input  logic       ev_disc,
  input  logic       ev_intfly,
  input  logic       sip_in,
  input  logic       dip_in,
  input  logic       cfg_wr,
  input  logic       cfg_compat,
  output logic       compat_mode,
  output logic       ops_rst,
  output logic       irq
);
  logic srst, sigp, sem, con, intf;
  logic srst_nx, con_set, unused_wbits;

  assign srst_nx = host_wr ? host_wdata[6] : srst;
  assign con_set = ev_sel_done | ev_resp_sel | ev_arb_won;
  assign unused_wbits = ^{host_wdata[7], host_wdata[3], host_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) compat_mode <= 1'b0;
    else if (cfg_wr) compat_mode <= cfg_compat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) srst <= 1'b0;
    else srst <= srst_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sigp <= 1'b0;
      sem  <= 1'b0;
      con  <= 1'b0;
      intf <= 1'b0;
    end else if (srst_nx) begin
      sigp <= 1'b0;
      sem  <= 1'b0;
      con  <= 1'b0;
      intf <= 1'b0;
    end else begin
      if (host_wr && host_wdata[5]) sigp <= 1'b1;
      else if (host_wr || tst_rd) sigp <= 1'b0;

      if ((host_wr && host_wdata[4]) || (seq_sem_wr && seq_sem_val)) sem <= 1'b1;
      else if (host_wr || seq_sem_wr) sem <= 1'b0;

      if (con_set) con <= 1'b1;
      else if (ev_disc) con <= 1'b0;

      if (ev_intfly) intf <= 1'b1;
      else if (host_wr && host_wdata[2]) intf <= 1'b0;
    end

  assign host_rdata = {1'b0, srst, sigp, sem, con, intf, sip_in, dip_in};
  assign tst_sigp   = sigp;
  assign sel_abort  = sigp & seq_wait_sel;
  assign ops_rst    = srst;
  assign irq        = sip_in | dip_in | intf;
endmodule

module isr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       seq_wait_sel,
  input logic       sel_abort,
  input logic       ev_sel_done,
  input logic       ev_resp_sel,
  input logic       ev_arb_won,
  input logic       ev_intfly,
  input logic       cfg_wr,
  input logic       compat_mode,
  input logic       ops_rst,
  input logic       irq
);
  p_srst_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[6] && !(host_wr && !host_wdata[6]) |=> host_rdata[6]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[6] |-> (host_rdata[5:2] == 4'b0) && ops_rst);

  p_compat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(compat_mode));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_abort |-> host_rdata[5] && seq_wait_sel);

  p_con_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel_done || ev_resp_sel || ev_arb_won) && !host_rdata[6] &&
    !(host_wr && host_wdata[6]) |=> host_rdata[3]);

  p_intf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_intfly && !host_rdata[6] && !(host_wr && host_wdata[6]) |=> host_rdata[2]);

  p_intf_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[2] && !(host_wr && (host_wdata[2] || host_wdata[6])) |=> host_rdata[2]);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[2] |-> irq);
endmodule

bind isr_ctl isr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .seq_wait_sel(seq_wait_sel), .sel_abort(sel_abort),
  .ev_sel_done(ev_sel_done), .ev_resp_sel(ev_resp_sel), .ev_arb_won(ev_arb_won),
  .ev_intfly(ev_intfly), .cfg_wr(cfg_wr), .compat_mode(compat_mode),
  .ops_rst(ops_rst), .irq(irq));

// File: tb/sim_isr_ctl.sv
module sim_isr_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, seq_sem_wr = 0, seq_sem_val = 0, tst_rd = 0, seq_wait_sel = 0;
  logic ev_sel_done = 0, ev_resp_sel = 0, ev_arb_won = 0, ev_disc = 0, ev_intfly = 0;
  logic sip_in = 0, dip_in = 0, cfg_wr = 0, cfg_compat = 0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic tst_sigp, sel_abort, compat_mode, ops_rst, irq;

  int total = 0, bad = 0;
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  isr_ctl u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: caller has set inputs after a falling edge
  task automatic step(string tag, logic [7:0] exp);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; seq_sem_wr = 0; tst_rd = 0; cfg_wr = 0;
    ev_sel_done = 0; ev_resp_sel = 0; ev_arb_won = 0; ev_disc = 0; ev_intfly = 0;
  endtask

  task automatic hw(logic [7:0] d);
    host_wr = 1; host_wdata = d;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q_exp.size() != 0) chk(q_tag.pop_front(), host_rdata, q_exp.pop_front());
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", host_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 compat after reset", {7'b0, compat_mode}, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    cfg_wr = 1; cfg_compat = 1; step("R4 cfg write", 8'h00);
    chk("R4 compat set", {7'b0, compat_mode}, 8'h01);

    hw(8'h20); step("R5 host sets sigp", 8'h20);
    seq_wait_sel = 1; tst_rd = 1; #1;
    chk("R6 sel_abort", {7'b0, sel_abort}, 8'h01);
    chk("R5 tst_sigp", {7'b0, tst_sigp}, 8'h01);
    step("R5 tst_rd clears", 8'h00);
    #1 chk("R6 no abort when clear", {7'b0, sel_abort}, 8'h00);
    seq_wait_sel = 0;
    hw(8'h20); tst_rd = 1; step("R5 set wins over tst_rd", 8'h20);
    #1 chk("R6 no abort without wait", {7'b0, sel_abort}, 8'h00);
    hw(8'h00); step("R5 host clears sigp", 8'h00);

    seq_sem_wr = 1; seq_sem_val = 1; step("R7 seq sets sem", 8'h10);
    hw(8'h00); step("R7 host clears sem", 8'h00);
    hw(8'h10); step("R7 host sets sem", 8'h10);
    hw(8'h00); seq_sem_wr = 1; seq_sem_val = 1; step("R7 one wins", 8'h10);
    seq_sem_wr = 1; seq_sem_val = 0; step("R7 seq clears sem", 8'h00);

    ev_sel_done = 1; step("R8 sel done", 8'h08);
    ev_disc = 1; step("R8 disc", 8'h00);
    ev_resp_sel = 1; step("R8 resp sel", 8'h08);
    ev_disc = 1; ev_arb_won = 1; step("R8 set wins", 8'h08);
    hw(8'h00); step("R8 host write no effect", 8'h08);
    ev_disc = 1; step("R8 disc again", 8'h00);
    ev_arb_won = 1; step("R8 arb won", 8'h08);

    ev_intfly = 1; step("R9 intfly sets", 8'h0C);
    #1 chk("R10 irq from intf", {7'b0, irq}, 8'h01);
    step("R9 survives idle read", 8'h0C);
    hw(8'h00); step("R9 write zero ignored", 8'h0C);
    hw(8'h04); step("R9 w1c", 8'h08);
    #1 chk("R10 irq low", {7'b0, irq}, 8'h00);
    ev_intfly = 1; step("R9 set again", 8'h0C);
    ev_intfly = 1; hw(8'h04); step("R9 set wins over w1c", 8'h0C);
    hw(8'h04); step("R9 w1c again", 8'h08);

    sip_in = 1; #1;
    chk("R10 sip copy", host_rdata, 8'h0A);
    chk("R10 irq from sip", {7'b0, irq}, 8'h01);
    sip_in = 0; dip_in = 1; hw(8'h83); #1;
    chk("R10 dip copy", host_rdata, 8'h09);
    step("R10 ro bits and bit7", 8'h09);
    dip_in = 0; #1 chk("R10 irq idle", {7'b0, irq}, 8'h00);

    hw(8'h30); ev_intfly = 1; step("R3 preload flags", 8'h3C);
    hw(8'h40); step("R3 srst clears flags", 8'h40);
    chk("R3 ops_rst", {7'b0, ops_rst}, 8'h01);
    chk("R4 compat survives srst", {7'b0, compat_mode}, 8'h01);
    ev_intfly = 1; ev_sel_done = 1; seq_sem_wr = 1; seq_sem_val = 1;
    step("R3 events held", 8'h40);
    hw(8'h74); step("R3 writes held", 8'h40);
    step("R2 sticky", 8'h40);
    hw(8'h00); step("R2 host release", 8'h00);
    chk("R3 ops_rst released", {7'b0, ops_rst}, 8'h00);

    hw(8'h40); step("R2 set before hw reset", 8'h40);
    rst_n = 0; #1;
    chk("R1 hw reset clears srst", host_rdata, 8'h00);
    chk("R1 hw reset clears compat", {7'b0, compat_mode}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule